// File: doc/BRIEF.md
# Shared-RAM Host Access Port

This block gives a host processor an indirect, byte-wide window into the RAM that it shares with a coprocessor. The host selects one of four registers with a 2-bit select and issues single-cycle read or write strobes. It sets a 16-bit RAM pointer one byte at a time, through a low-byte register and a high-byte register. It then moves bytes through a single data register. When stepping is enabled, each data access advances the pointer, so a whole block of code or a message buffer can be streamed without reloading the pointer.

A control/status register sits beside the data path. It holds the coprocessor run enable, the pointer-step enable, a bypass bit, a doorbell toward the coprocessor, and two interrupt flags raised by the coprocessor. Both flags drive one host interrupt line. The host tells them apart by reading the register, and it acknowledges a flag by writing a 1 to that flag's bit. A plain side port stands in for the coprocessor core. Through it the coprocessor raises the flags, sees the doorbell, and acknowledges the doorbell. The RAM array is held inside the block. Only the low `MEM_AW` bits of the pointer index it, so the array repeats across the 16-bit space.

Top module: `shram_host_port`

## Requirements
- R1: After reset the control register reads 0x00, both pointer bytes read 0x00, `host_irq` is low and `cp_run`, `cp_bypass` and `cp_bell` are low.
- R2: A write to select 2 loads pointer bits 7:0 and a write to select 3 loads pointer bits 15:8. Reading select 2 or 3 returns the matching pointer byte.
- R3: A write to select 1 stores the byte at the current pointer. A read strobe on any select puts the addressed value on `h_rdata` at the next clock edge, and `h_rdata` holds that value until the next read.
- R4: With the step bit (bit 1) set, each data-register access advances the pointer by one after the access. With the step bit clear, the pointer does not change on a data access.
- R5: A step from pointer 0xFFFF gives 0x0000.
- R6: Bits 0 (run), 1 (step) and 2 (bypass) of the control register take the written value on every control write. Each reads back independently of the others, and `cp_run` and `cp_bypass` follow bits 0 and 2.
- R7: Writing 1 to control bit 3 (doorbell) sets it and raises `cp_bell`. Writing 0 to it leaves it unchanged, and a `cp_bell_ack` pulse clears it.
- R8: Control bits 4 and 5 are set by pulses on `cp_set_int0` and `cp_set_int1`. A host write of 1 to a flag clears it and a write of 0 leaves it unchanged. A set in the same cycle as a clear leaves the flag set.
- R9: `host_irq` is high exactly while bit 4 or bit 5 is set.
- R10: The RAM is indexed by the low `MEM_AW` pointer bits, so pointers that differ only above that field reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 2 | Register select: 0 control, 1 data, 2 pointer low, 3 pointer high |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (ignored while h_wr is high) |
| h_wdata | input | BYTE_W | Host write data |
| h_rdata | output | BYTE_W | Registered host read data |
| host_irq | output | 1 | Combined host interrupt |
| cp_set_int0 | input | 1 | Coprocessor pulse that sets flag 0 |
| cp_set_int1 | input | 1 | Coprocessor pulse that sets flag 1 |
| cp_bell_ack | input | 1 | Coprocessor pulse that clears the doorbell |
| cp_run | output | 1 | Run enable toward the coprocessor |
| cp_bypass | output | 1 | Bypass bit toward the coprocessor |
| cp_bell | output | 1 | Doorbell toward the coprocessor |

## Verification
The bench builds the port with `MEM_AW` = 6, so the RAM holds 64 bytes. With that size, one stepped pass writes every byte and a second pass reads every byte back, each compared against an arithmetic pattern. The small array also lets the bench reach the aliasing case cheaply, using pointers 0x1234 and 0x0034. It reaches the wrap from 0xFFFF, which lands back on the array's top byte. The three plain control bits are swept over all eight combinations, and the flag and doorbell sequences include a set and a clear arriving in the same cycle.

// File: rtl/shram_pkg.sv
package shram_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_DATA = 2'd1,
      SEL_PLO  = 2'd2,
      SEL_PHI  = 2'd3
   } reg_sel_e;

   localparam int BIT_RUN  = 0;
   localparam int BIT_STEP = 1;
   localparam int BIT_BYP  = 2;
   localparam int BIT_BELL = 3;
   localparam int BIT_F0   = 4;
   localparam int BIT_F1   = 5;
   localparam int CTRL_W   = 6;
   localparam int NUM_FLAGS = 2;

   typedef struct packed {
      logic [NUM_FLAGS-1:0] flag;
      logic                 bell;
      logic                 bypass;
      logic                 step;
      logic                 run;
   } ctrl_s;

endpackage

// File: rtl/shram_ptr.sv
module shram_ptr #(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

   generate
      if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
         $error("shram_ptr: ADDR_W must be two bytes wide");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr <= '0;
      else if (ld_lo) ptr[BYTE_W-1:0] <= wdata;
      else if (ld_hi) ptr[ADDR_W-1:BYTE_W] <= wdata;
      else if (step)  ptr <= ptr + PTR_ONE;
   end

   // R4: a step advances the pointer by exactly one
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_lo && !ld_hi) |=> ptr == $past(ptr) + PTR_ONE);

   // R4: without load or step the pointer holds
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ld_lo && !ld_hi) |=> $stable(ptr));

   // R5: stepping from the top wraps to zero
   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_lo && !ld_hi && ptr == PTR_MAX) |=> ptr == '0);

endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
   import shram_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic [NUM_FLAGS-1:0] flag_set,
   input  logic              bell_ack,
   output ctrl_s             st
);
   logic [NUM_FLAGS-1:0] flag_d;
   logic [NUM_FLAGS-1:0] flag_clr;
   logic                 ring;

   assign ring = wr & wdata[BIT_BELL];

   genvar g;
   generate
      for (g = 0; g < NUM_FLAGS; g++) begin : g_flag
         assign flag_clr[g] = wr & wdata[BIT_F0 + g];
         // a set from the coprocessor wins over a host clear
         assign flag_d[g]   = flag_set[g] | (st.flag[g] & ~flag_clr[g]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         st.flag <= flag_d;
         st.bell <= ring | (st.bell & ~bell_ack);
         if (wr) begin
            st.run    <= wdata[BIT_RUN];
            st.step   <= wdata[BIT_STEP];
            st.bypass <= wdata[BIT_BYP];
         end
      end
   end

   // R7: an acknowledge with no new ring clears the doorbell
   assert_bell_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bell_ack && !ring) |=> !st.bell);

   // R7: a ring always leaves the doorbell set
   assert_bell_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ring |=> st.bell);

   // R8: a set pulse leaves flag 0 set, even against a clear
   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[0] |=> st.flag[0]);

   // R8: a clear with no set drops flag 1
   assert_flag_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[BIT_F1] && !flag_set[1]) |=> !st.flag[1]);

endmodule

// File: rtl/shram_ram.sv
module shram_ram #(
   parameter int MEM_AW = 10,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [MEM_AW-1:0] idx,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);
   localparam int DEPTH = 1 << MEM_AW;

   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
   import shram_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        h_sel,
   input  logic              h_wr,
   input  logic              h_rd,
   input  logic [BYTE_W-1:0] h_wdata,
   output logic [BYTE_W-1:0] h_rdata,
   output logic              host_irq,
   input  logic              cp_set_int0,
   input  logic              cp_set_int1,
   input  logic              cp_bell_ack,
   output logic              cp_run,
   output logic              cp_bypass,
   output logic              cp_bell
);
   localparam int PAD_W = BYTE_W - CTRL_W;

   generate
      if (MEM_AW > ADDR_W || MEM_AW < 1) begin : g_bad_mem
         $error("shram_host_port: MEM_AW out of range");
      end
      if (PAD_W < 0) begin : g_bad_byte
         $error("shram_host_port: byte too narrow for control bits");
      end
   endgenerate

   reg_sel_e          sel;
   logic              rd_only;
   logic              data_acc;
   logic              wr_ctrl;
   logic [ADDR_W-1:0] ptr;
   logic [MEM_AW-1:0] mem_idx;
   logic [BYTE_W-1:0] ram_q;
   logic [BYTE_W-1:0] ctrl_rd;
   ctrl_s             st;

   assign sel      = reg_sel_e'(h_sel);
   assign rd_only  = h_rd & ~h_wr;
   assign data_acc = (h_wr | h_rd) & (sel == SEL_DATA);
   assign wr_ctrl  = h_wr & (sel == SEL_CTRL);

   shram_ptr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (h_wr & (sel == SEL_PLO)),
      .ld_hi (h_wr & (sel == SEL_PHI)),
      .wdata (h_wdata),
      .step  (data_acc & st.step),
      .ptr   (ptr)
   );

   shram_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_ctrl),
      .wdata    (h_wdata[CTRL_W-1:0]),
      .flag_set ({cp_set_int1, cp_set_int0}),
      .bell_ack (cp_bell_ack),
      .st       (st)
   );

   generate
      if (MEM_AW == ADDR_W) begin : g_full_idx
         assign mem_idx = ptr;
      end else begin : g_alias_idx
         assign mem_idx = ptr[MEM_AW-1:0];
      end
      if (PAD_W > 0) begin : g_pad
         assign ctrl_rd = {{PAD_W{1'b0}}, st};
      end else begin : g_nopad
         assign ctrl_rd = st;
      end
   endgenerate

   shram_ram #(.MEM_AW(MEM_AW), .BYTE_W(BYTE_W)) u_ram (
      .clk   (clk),
      .we    (h_wr & (sel == SEL_DATA)),
      .idx   (mem_idx),
      .wdata (h_wdata),
      .rdata (ram_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_rdata <= '0;
      end else if (rd_only) begin
         unique case (sel)
            SEL_CTRL: h_rdata <= ctrl_rd;
            SEL_DATA: h_rdata <= ram_q;
            SEL_PLO:  h_rdata <= ptr[BYTE_W-1:0];
            SEL_PHI:  h_rdata <= ptr[ADDR_W-1:BYTE_W];
         endcase
      end
   end

   assign host_irq  = |st.flag;
   assign cp_run    = st.run;
   assign cp_bypass = st.bypass;
   assign cp_bell   = st.bell;

   // R9: any raise from the coprocessor shows on the interrupt line next cycle
   assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_set_int0 || cp_set_int1) |=> host_irq);

   // R3: read data only changes after a read strobe
   assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_only |=> $stable(h_rdata));

endmodule

// File: tb/sim_shram_host_port.sv
module sim_shram_host_port;
   localparam int MAW = 6;
   localparam int NB  = 1 << MAW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] h_sel = 2'd0;
   logic       h_wr = 1'b0;
   logic       h_rd = 1'b0;
   logic [7:0] h_wdata = 8'd0;
   logic [7:0] h_rdata;
   logic       host_irq;
   logic       cp_set_int0 = 1'b0;
   logic       cp_set_int1 = 1'b0;
   logic       cp_bell_ack = 1'b0;
   logic       cp_run, cp_bypass, cp_bell;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   shram_host_port #(.ADDR_W(16), .BYTE_W(8), .MEM_AW(MAW)) u0 (
      .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd),
      .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq(host_irq),
      .cp_set_int0(cp_set_int0), .cp_set_int1(cp_set_int1),
      .cp_bell_ack(cp_bell_ack), .cp_run(cp_run), .cp_bypass(cp_bypass),
      .cp_bell(cp_bell)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 91) & 255);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      h_sel = s; h_wdata = d; h_wr = 1'b1;
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic hrd(input logic [1:0] s, output logic [7:0] d);
      @(negedge clk);
      h_sel = s; h_rd = 1'b1;
      @(negedge clk);
      h_rd = 1'b0;
      d = h_rdata;
   endtask

   task automatic set_ptr(input logic [15:0] p);
      hwr(2'd2, p[7:0]);
      hwr(2'd3, p[15:8]);
   endtask

   task automatic pulse_f0();
      @(negedge clk); cp_set_int0 = 1'b1;
      @(negedge clk); cp_set_int0 = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      hrd(2'd0, v); chk("R1 ctrl", v, 8'h00);
      hrd(2'd2, v); chk("R1 ptr lo", v, 8'h00);
      hrd(2'd3, v); chk("R1 ptr hi", v, 8'h00);
      chk("R1 outputs", {4'd0, host_irq, cp_run, cp_bypass, cp_bell}, 8'h00);

      // R6 sweep of run/step/bypass
      for (int c = 0; c < 8; c++) begin
         hwr(2'd0, 8'(c));
         hrd(2'd0, v); chk("R6 readback", v, 8'(c));
         chk("R6 side port", {6'd0, cp_bypass, cp_run}, {6'd0, 1'(c >> 2), 1'(c)});
      end

      // R3 R4 stepped fill and read-back of the whole array
      hwr(2'd0, 8'h02);
      set_ptr(16'h0000);
      for (int a = 0; a < NB; a++) hwr(2'd1, pat(a));
      hrd(2'd2, v); chk("R4 ptr after fill", v, 8'(NB));
      hrd(2'd3, v); chk("R4 ptr hi after fill", v, 8'h00);
      set_ptr(16'h0000);
      for (int a = 0; a < NB; a++) begin
         hrd(2'd1, v); chk("R3 stream read", v, pat(a));
      end

      // R2 R4 fixed pointer, step off
      hwr(2'd0, 8'h00);
      set_ptr(16'h1234);
      hrd(2'd2, v); chk("R2 ptr lo", v, 8'h34);
      hrd(2'd3, v); chk("R2 ptr hi", v, 8'h12);
      hwr(2'd1, 8'hA5);
      hrd(2'd1, v); chk("R3 read at fixed ptr", v, 8'hA5);
      hrd(2'd1, v); chk("R4 repeat read no step", v, 8'hA5);
      hrd(2'd2, v); chk("R4 ptr held lo", v, 8'h34);
      hrd(2'd3, v); chk("R4 ptr held hi", v, 8'h12);

      // R10 aliasing: 0x0034 and 0x1234 share low six bits
      set_ptr(16'h0034);
      hrd(2'd1, v); chk("R10 alias", v, 8'hA5);
      set_ptr(16'h0035);
      hrd(2'd1, v); chk("R10 neighbour untouched", v, pat(16'h35));

      // R5 wrap
      hwr(2'd0, 8'h02);
      set_ptr(16'hFFFF);
      hwr(2'd1, 8'h5A);
      hrd(2'd2, v); chk("R5 wrap lo", v, 8'h00);
      hrd(2'd3, v); chk("R5 wrap hi", v, 8'h00);
      set_ptr(16'h003F);
      hrd(2'd1, v); chk("R5 byte at top", v, 8'h5A);

      // R7 doorbell
      hwr(2'd0, 8'h0B);
      hrd(2'd0, v); chk("R7 ring", v, 8'h0B);
      chk("R7 cp_bell", {7'd0, cp_bell}, 8'h01);
      hwr(2'd0, 8'h03);
      hrd(2'd0, v); chk("R7 zero write keeps bell", v, 8'h0B);
      @(negedge clk); cp_bell_ack = 1'b1;
      @(negedge clk); cp_bell_ack = 1'b0;
      hrd(2'd0, v); chk("R7 ack clears", v, 8'h03);
      chk("R7 cp_bell low", {7'd0, cp_bell}, 8'h00);

      // R8 R9 flags
      pulse_f0();
      hrd(2'd0, v); chk("R8 flag0 set", v, 8'h13);
      chk("R9 irq on", {7'd0, host_irq}, 8'h01);
      hwr(2'd0, 8'h03);
      hrd(2'd0, v); chk("R8 zero write keeps flag", v, 8'h13);
      @(negedge clk); cp_set_int1 = 1'b1;
      @(negedge clk); cp_set_int1 = 1'b0;
      hrd(2'd0, v); chk("R8 both flags", v, 8'h33);
      hwr(2'd0, 8'h13);
      hrd(2'd0, v); chk("R8 ack flag0", v, 8'h23);
      chk("R9 irq flag1 only", {7'd0, host_irq}, 8'h01);
      @(negedge clk);
      h_sel = 2'd0; h_wdata = 8'h23; h_wr = 1'b1; cp_set_int1 = 1'b1;
      @(negedge clk);
      h_wr = 1'b0; cp_set_int1 = 1'b0;
      hrd(2'd0, v); chk("R8 set beats clear", v, 8'h23);
      hwr(2'd0, 8'h23);
      hrd(2'd0, v); chk("R8 ack flag1", v, 8'h03);
      chk("R9 irq off", {7'd0, host_irq}, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule